// File: doc/BRIEF.md
# Serial Character Receiver with Host-Requested Sleep

This block turns a serial line into 8-bit characters and reports each one on a set of single-cycle status pulses. The clock recovery that feeds it lies outside the block. It hands over three samples of the line for every bit, together with a one-cycle bit strobe. A majority vote over the three samples gives the bit value. Any disagreement among the samples is reported as noise.

The host can put the receiver to sleep with a one-cycle request. While asleep, the receiver discards incoming characters, raises no status and holds off its interrupt. A select input picks one of two wake conditions: a quiet line lasting a full frame time, or a character that carries an address mark. When the chosen condition occurs, the block clears its sleep bit by itself. A character that wakes the receiver by its address mark is delivered like any other.

A held data-present flag drives the interrupt. The host clears that flag with a read acknowledge. If a character completes while the flag is still set, the block reports overrun and drops the new character.

The receiver state machine `urxw_deser` has four states:

- `RX_IDLE`: on a strobe with the line at 0 it goes to `RX_DATA`.
- `RX_DATA`: after the eighth data bit it goes to `RX_NINTH` when the 9th bit is enabled, and to `RX_STOP` otherwise.
- `RX_NINTH`: it always goes to `RX_STOP`.
- `RX_STOP`: it always returns to `RX_IDLE`.

The sleep machine `urxw_wake` has two states:

- `WK_AWAKE` goes to `WK_ASLEEP` on a sleep request.
- `WK_ASLEEP` returns to `WK_AWAKE` when it sees an idle period (idle-wake mode) or an address-marked character (mark-wake mode).

Top module: `uart_rx_wake`

## Requirements
- R1: A frame is one start bit at 0, eight data bits sent LSB first, a 9th bit when `cfg_ninth`=1, then a stop bit. A completed frame loads `rx_data` and `rx_ninth` and gives a one-cycle `rdy_p`.
- R2: A stop bit sampled at 0 raises `frm_p` in the same cycle as `rdy_p`.
- R3: When `cfg_ninth`=1 and `cfg_par`=1, the 9th bit is even parity: the XOR of the 8 data bits and the 9th bit must be 0. A mismatch raises `par_p` in the same cycle as `rdy_p`.
- R4: `rx_smp` holds three samples per bit, and the majority gives the bit value. If the samples of any bit from start to stop disagree, `noise_p` is raised in the same cycle as `rdy_p`.
- R5: `irq` is a held data-present flag. `rdy_p` sets it and `rd_ack` clears it. A frame that completes while it is set (with no `rd_ack` in that cycle) gives `ovr_p` without `rdy_p` and leaves `rx_data` unchanged.
- R6: While awake, the line staying at 1 for a frame time after a character gives exactly one `idle_p`. A frame time is 10 strobes, or 11 when `cfg_ninth`=1. Further idle strobes give no more pulses until the next character.
- R7: A `sleep_set` pulse sets `asleep`. While asleep, characters are discarded, no status pulse is raised, `rx_data` does not change and `irq` does not rise.
- R8: With `wake_sel`=0, `asleep` clears after one frame time of consecutive idle strobes. The count starts at the request or at the last start bit. This wake gives no `idle_p`.
- R9: With `wake_sel`=1, only a character whose address mark is 1 wakes the receiver. That character is delivered with `rdy_p`. The mark is the 9th bit when `cfg_ninth`=1 and `cfg_par`=0, and data bit 7 otherwise. Idle periods do not wake in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_smp | input | 3 | Three line samples for the current bit |
| cfg_ninth | input | 1 | Frame carries a 9th bit |
| cfg_par | input | 1 | 9th bit is even parity |
| wake_sel | input | 1 | Wake condition: 0 idle line, 1 address mark |
| sleep_set | input | 1 | Host pulse that requests sleep |
| rd_ack | input | 1 | Host pulse that clears the data-present flag |
| rx_data | output | 8 | Last delivered character |
| rx_ninth | output | 1 | 9th bit of the last delivered character |
| asleep | output | 1 | Sleep bit, cleared by hardware on wake |
| rdy_p | output | 1 | Character delivered |
| idle_p | output | 1 | Idle line detected |
| ovr_p | output | 1 | Character dropped by overrun |
| noise_p | output | 1 | Sample disagreement in the delivered frame |
| frm_p | output | 1 | Stop bit at 0 |
| par_p | output | 1 | Parity mismatch |
| irq | output | 1 | Receive interrupt request |

## Verification
Random frames vary the data, the frame width, the parity setting, the stop bit value and the position of a single noisy sample. This separates the data path from each error flag and shows that every flag arrives together with the data-ready pulse. Directed sequences cover the sleep and wake behaviour:

- A discarded character followed by an idle run one strobe short of, and then exactly at, a frame time fixes the idle-wake threshold.
- Unmarked characters and long idle runs in mark-wake mode show that only a marked character wakes the receiver, for both mark positions.
- Two frames without an acknowledge separate overrun from normal delivery.
- An idle run after a character shows that the idle pulse fires exactly once.

// File: rtl/urxw_pkg.sv
package urxw_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_DATA  = 2'd1,
        RX_NINTH = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    typedef enum logic {
        WK_AWAKE  = 1'b0,
        WK_ASLEEP = 1'b1
    } wake_state_t;

    localparam logic WAKE_BY_IDLE = 1'b0;
    localparam logic WAKE_BY_MARK = 1'b1;
endpackage

// File: rtl/urxw_vote.sv
module urxw_vote #(
    parameter int SMP = 3
) (
    input  logic [SMP-1:0] smp,
    output logic           line_bit,
    output logic           line_noisy
);
    localparam int CW = $clog2(SMP + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < SMP; i++) begin
            ones = ones + CW'(smp[i]);
        end
    end

    assign line_bit   = ones > CW'(SMP / 2);
    assign line_noisy = (ones != '0) && (ones != CW'(SMP));
endmodule

// File: rtl/urxw_deser.sv
module urxw_deser
    import urxw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              line_bit,
    input  logic              line_noisy,
    input  logic              cfg_ninth,
    output logic              frame_done,
    output logic [DATA_W-1:0] f_data,
    output logic              f_ninth,
    output logic              f_stop_ok,
    output logic              f_noisy,
    output logic              start_hit,
    output logic              idle_one
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              ninth_q, stop_q, noise_q, done_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (bit_tick) begin
            unique case (state_q)
                RX_IDLE:  if (!line_bit) state_d = RX_DATA;
                RX_DATA:  if (cnt_q == LAST) state_d = cfg_ninth ? RX_NINTH : RX_STOP;
                RX_NINTH: state_d = RX_STOP;
                RX_STOP:  state_d = RX_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            ninth_q <= 1'b0;
            stop_q  <= 1'b1;
            noise_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bit_tick) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (!line_bit) begin
                            cnt_q   <= '0;
                            ninth_q <= 1'b0;
                            noise_q <= line_noisy;
                        end
                    end
                    RX_DATA: begin
                        sh_q    <= {line_bit, sh_q[DATA_W-1:1]};
                        cnt_q   <= cnt_q + 1'b1;
                        noise_q <= noise_q | line_noisy;
                    end
                    RX_NINTH: begin
                        ninth_q <= line_bit;
                        noise_q <= noise_q | line_noisy;
                    end
                    RX_STOP: begin
                        stop_q  <= line_bit;
                        noise_q <= noise_q | line_noisy;
                        done_q  <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign frame_done = done_q;
    assign f_data     = sh_q;
    assign f_ninth    = ninth_q;
    assign f_stop_ok  = stop_q;
    assign f_noisy    = noise_q;
    assign start_hit  = bit_tick && (state_q == RX_IDLE) && !line_bit;
    assign idle_one   = bit_tick && (state_q == RX_IDLE) && line_bit;
endmodule

// File: rtl/urxw_wake.sv
module urxw_wake
    import urxw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_set,
    input  logic wake_sel,
    input  logic cfg_ninth,
    input  logic idle_one,
    input  logic start_hit,
    input  logic frame_done,
    input  logic addr_mark,
    output logic asleep,
    output logic deliver,
    output logic idle_evt
);
    localparam int LEN_SHORT = DATA_W + 2;
    localparam int LEN_LONG  = DATA_W + 3;
    localparam int IW        = $clog2(LEN_LONG + 1);

    wake_state_t   wst_q, wst_d;
    logic [IW-1:0] idle_cnt_q;
    logic [IW-1:0] frame_len;
    logic          armed_q;
    logic          idle_reach, wake_idle, wake_mark, cnt_clear;

    assign frame_len  = cfg_ninth ? IW'(LEN_LONG) : IW'(LEN_SHORT);
    assign cnt_clear  = start_hit || sleep_set;
    assign idle_reach = idle_one && !cnt_clear && (idle_cnt_q == frame_len - 1'b1);
    assign wake_idle  = (wst_q == WK_ASLEEP) && (wake_sel == WAKE_BY_IDLE) && idle_reach;
    assign wake_mark  = (wst_q == WK_ASLEEP) && (wake_sel == WAKE_BY_MARK) && frame_done && addr_mark;

    // Next-state logic
    always_comb begin
        wst_d = wst_q;
        unique case (wst_q)
            WK_AWAKE:  if (sleep_set) wst_d = WK_ASLEEP;
            WK_ASLEEP: if (!sleep_set && (wake_idle || wake_mark)) wst_d = WK_AWAKE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wst_q <= WK_AWAKE;
        else        wst_q <= wst_d;
    end

    // Idle period counter and idle arm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
            armed_q    <= 1'b0;
        end else begin
            if (cnt_clear)                                idle_cnt_q <= '0;
            else if (idle_one && idle_cnt_q < frame_len)  idle_cnt_q <= idle_cnt_q + 1'b1;
            if (frame_done)      armed_q <= 1'b1;
            else if (idle_reach) armed_q <= 1'b0;
        end
    end

    assign asleep   = (wst_q == WK_ASLEEP);
    assign deliver  = frame_done && ((wst_q == WK_AWAKE) || wake_mark);
    assign idle_evt = idle_reach && armed_q && (wst_q == WK_AWAKE);
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
    parameter int   DATA_W  = 8,
    parameter int   SMP     = 3,
    parameter logic PAR_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [SMP-1:0]    rx_smp,
    input  logic              cfg_ninth,
    input  logic              cfg_par,
    input  logic              wake_sel,
    input  logic              sleep_set,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              asleep,
    output logic              rdy_p,
    output logic              idle_p,
    output logic              ovr_p,
    output logic              noise_p,
    output logic              frm_p,
    output logic              par_p,
    output logic              irq
);
    logic              line_bit, line_noisy;
    logic              frame_done, f_ninth, f_stop_ok, f_noisy;
    logic [DATA_W-1:0] f_data;
    logic              start_hit, idle_one;
    logic              addr_mark, deliver, idle_evt, par_bad;
    logic              full_q;

    urxw_vote #(.SMP(SMP)) u_vote (
        .smp        (rx_smp),
        .line_bit   (line_bit),
        .line_noisy (line_noisy)
    );

    urxw_deser #(.DATA_W(DATA_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .line_bit   (line_bit),
        .line_noisy (line_noisy),
        .cfg_ninth  (cfg_ninth),
        .frame_done (frame_done),
        .f_data     (f_data),
        .f_ninth    (f_ninth),
        .f_stop_ok  (f_stop_ok),
        .f_noisy    (f_noisy),
        .start_hit  (start_hit),
        .idle_one   (idle_one)
    );

    assign addr_mark = (cfg_ninth && !cfg_par) ? f_ninth : f_data[DATA_W-1];
    assign par_bad   = cfg_ninth && cfg_par && ((^{f_data, f_ninth}) != PAR_ODD);

    urxw_wake #(.DATA_W(DATA_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_set  (sleep_set),
        .wake_sel   (wake_sel),
        .cfg_ninth  (cfg_ninth),
        .idle_one   (idle_one),
        .start_hit  (start_hit),
        .frame_done (frame_done),
        .addr_mark  (addr_mark),
        .asleep     (asleep),
        .deliver    (deliver),
        .idle_evt   (idle_evt)
    );

    // Status pulses, receive holding register and data-present flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ninth <= 1'b0;
            full_q   <= 1'b0;
            rdy_p    <= 1'b0;
            idle_p   <= 1'b0;
            ovr_p    <= 1'b0;
            noise_p  <= 1'b0;
            frm_p    <= 1'b0;
            par_p    <= 1'b0;
        end else begin
            rdy_p   <= 1'b0;
            ovr_p   <= 1'b0;
            noise_p <= 1'b0;
            frm_p   <= 1'b0;
            par_p   <= 1'b0;
            idle_p  <= idle_evt;
            if (rd_ack) full_q <= 1'b0;
            if (deliver) begin
                if (full_q && !rd_ack) begin
                    ovr_p <= 1'b1;
                end else begin
                    rdy_p    <= 1'b1;
                    full_q   <= 1'b1;
                    rx_data  <= f_data;
                    rx_ninth <= f_ninth;
                    frm_p    <= !f_stop_ok;
                    noise_p  <= f_noisy;
                    par_p    <= par_bad;
                end
            end
        end
    end

    assign irq = full_q;
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_set,
    input logic              wake_sel,
    input logic              asleep,
    input logic              rdy_p,
    input logic              idle_p,
    input logic              ovr_p,
    input logic              noise_p,
    input logic              frm_p,
    input logic              par_p,
    input logic              irq,
    input logic [DATA_W-1:0] rx_data
);
    // R2 R3 R4: error flags only accompany a delivered character
    a_r2_errors_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_p || par_p || noise_p) |-> rdy_p);

    // R5: an overrun never delivers and needs a held character
    a_r5_ovr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_p |-> (!rdy_p && $past(irq)));

    // R5: the holding register only changes on delivery
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_p |-> $stable(rx_data));

    // R7: no status while asleep
    a_r7_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep) && !$past(sleep_set)) |->
        !(rdy_p || ovr_p || frm_p || noise_p || par_p || idle_p));

    // R7: interrupt held off while asleep
    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep) && !$past(sleep_set)) |-> !$rose(irq));

    // R8: an idle wake raises no idle pulse
    a_r8_idle_wake_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && !$past(wake_sel)) |-> !idle_p);

    // R9: a mark wake delivers (or overruns) the waking character
    a_r9_mark_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && $past(wake_sel)) |-> (rdy_p || ovr_p));
endmodule

bind uart_rx_wake uart_rx_wake_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_uart_rx_wake.sv
`timescale 1ns/1ps
module sim_uart_rx_wake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [2:0] rx_smp = 3'b111;
    logic       cfg_ninth = 1'b0, cfg_par = 1'b0, wake_sel = 1'b0;
    logic       sleep_set = 1'b0, rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ninth, asleep, rdy_p, idle_p, ovr_p, noise_p, frm_p, par_p, irq;

    int checks = 0, errors = 0;
    int n_rdy = 0, n_idle = 0, n_ovr = 0, n_noise = 0, n_frm = 0, n_par = 0;
    logic [7:0] cap_data = '0;

    always #4 clk = ~clk;

    uart_rx_wake u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_smp(rx_smp),
        .cfg_ninth(cfg_ninth), .cfg_par(cfg_par), .wake_sel(wake_sel),
        .sleep_set(sleep_set), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_ninth(rx_ninth), .asleep(asleep), .rdy_p(rdy_p), .idle_p(idle_p),
        .ovr_p(ovr_p), .noise_p(noise_p), .frm_p(frm_p), .par_p(par_p), .irq(irq)
    );

    always @(negedge clk) begin
        if (rdy_p) begin n_rdy++; cap_data = rx_data; end
        if (idle_p)  n_idle++;
        if (ovr_p)   n_ovr++;
        if (noise_p) n_noise++;
        if (frm_p)   n_frm++;
        if (par_p)   n_par++;
    end

    task automatic clr_caps();
        n_rdy = 0; n_idle = 0; n_ovr = 0; n_noise = 0; n_frm = 0; n_par = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic even_par_bad(input logic [7:0] d, input logic n9);
        return ^{d, n9};
    endfunction

    task automatic tick_bit(input logic v, input logic noisy);
        @(negedge clk);
        rx_smp   = noisy ? {v, v, ~v} : {3{v}};
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        rx_smp   = 3'b111;
        @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) tick_bit(1'b1, 1'b0);
    endtask

    // noise_at: -1 none, else bit index (0 = start)
    task automatic send_frame(input logic [7:0] d, input logic n9, input logic stp, input int noise_at);
        int idx = 0;
        tick_bit(1'b0, noise_at == idx); idx++;
        for (int i = 0; i < 8; i++) begin tick_bit(d[i], noise_at == idx); idx++; end
        if (cfg_ninth) begin tick_bit(n9, noise_at == idx); idx++; end
        tick_bit(stp, noise_at == idx);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_set = 1'b1;
        @(negedge clk); sleep_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic       n9, stp;
        int         nz, len;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset irq", irq, 0);
        chk("R7 reset asleep", asleep, 0);
        chk("R1 reset data", rx_data, 0);

        // Random frames: R1 R2 R3 R4
        for (int it = 0; it < 60; it++) begin
            cfg_ninth = $urandom % 2;
            cfg_par   = cfg_ninth & ($urandom % 2);
            d   = $urandom;
            n9  = $urandom;
            stp = ($urandom % 6) != 0;
            len = cfg_ninth ? 11 : 10;
            nz  = (($urandom % 4) == 0) ? int'($urandom % len) : -1;
            clr_caps();
            send_frame(d, n9, stp, nz);
            chk("R1 rdy", n_rdy, 1);
            chk("R1 data", cap_data, d);
            if (cfg_ninth) chk("R1 ninth", rx_ninth, n9);
            chk("R2 framing", n_frm, stp ? 0 : 1);
            chk("R3 parity", n_par, (cfg_ninth && cfg_par && even_par_bad(d, n9)) ? 1 : 0);
            chk("R4 noise", n_noise, (nz >= 0) ? 1 : 0);
            idle_bits(2);
            pulse_ack();
        end

        // Directed parity R3
        cfg_ninth = 1; cfg_par = 1;
        clr_caps(); send_frame(8'h01, 1'b1, 1'b1, -1);
        chk("R3 good parity", n_par, 0); pulse_ack();
        clr_caps(); send_frame(8'h01, 1'b0, 1'b1, -1);
        chk("R3 bad parity", n_par, 1); pulse_ack();
        cfg_ninth = 0; cfg_par = 0;

        // Overrun R5
        clr_caps(); send_frame(8'hA1, 1'b0, 1'b1, -1);
        chk("R5 irq set", irq, 1);
        idle_bits(1);
        clr_caps(); send_frame(8'hB2, 1'b0, 1'b1, -1);
        chk("R5 overrun", n_ovr, 1);
        chk("R5 no rdy", n_rdy, 0);
        chk("R5 data kept", rx_data, 8'hA1);
        pulse_ack(); @(negedge clk);
        chk("R5 irq cleared", irq, 0);

        // Idle pulse R6
        clr_caps(); send_frame(8'h44, 1'b0, 1'b1, -1); pulse_ack();
        idle_bits(9);
        chk("R6 before frame time", n_idle, 0);
        idle_bits(1); repeat (3) @(negedge clk);
        chk("R6 one idle", n_idle, 1);
        idle_bits(15);
        chk("R6 single pulse", n_idle, 1);

        // Sleep with idle wake R7 R8
        wake_sel = 0;
        pulse_sleep();
        chk("R7 asleep", asleep, 1);
        clr_caps(); send_frame(8'h3C, 1'b0, 1'b0, 3);
        chk("R7 discarded", n_rdy + n_frm + n_noise, 0);
        chk("R7 data kept", rx_data, 8'h44);
        chk("R7 irq low", irq, 0);
        idle_bits(9);
        chk("R8 still asleep", asleep, 1);
        idle_bits(1); repeat (2) @(negedge clk);
        chk("R8 woke", asleep, 0);
        chk("R8 no idle pulse", n_idle, 0);

        // Mark wake with 9th bit R9
        cfg_ninth = 1; cfg_par = 0; wake_sel = 1;
        pulse_sleep();
        clr_caps(); send_frame(8'hA5, 1'b0, 1'b1, -1);
        chk("R9 unmarked dropped", n_rdy, 0);
        idle_bits(25);
        chk("R9 idle no wake", asleep, 1);
        chk("R7 no idle while asleep", n_idle, 0);
        send_frame(8'h5A, 1'b1, 1'b1, -1);
        chk("R9 mark rdy", n_rdy, 1);
        chk("R9 mark data", cap_data, 8'h5A);
        chk("R9 woke", asleep, 0);
        idle_bits(2); pulse_ack();

        // Mark wake with bit 7 R9
        cfg_ninth = 0;
        pulse_sleep();
        clr_caps(); send_frame(8'h12, 1'b0, 1'b1, -1);
        chk("R9 bit7 clear dropped", n_rdy, 0);
        chk("R9 bit7 still asleep", asleep, 1);
        send_frame(8'h93, 1'b0, 1'b1, -1);
        chk("R9 bit7 rdy", n_rdy, 1);
        chk("R9 bit7 data", rx_data, 8'h93);
        chk("R9 bit7 woke", asleep, 0);
        pulse_ack();

        finish_run();
    end
endmodule